// File: doc/BRIEF.md
# Four-Bit-Parallel BCH Syndrome Unit

This unit forms the full set of 2T syndromes of a received binary BCH codeword. The codeword is built on a shortened primitive code over GF(2^M), which is GF(2^16) by default. It is the first stage of a decoder that protects a 4 Kbyte data page together with its parity. The received bits arrive as a stream of 4-bit beats, with the highest-order coefficient first. A beat is accepted on every clock in which the valid input is high. The beat marked last closes the codeword.

The unit keeps one Horner accumulator for each odd syndrome index j. On every beat that accumulator multiplies its value by alpha^(4j) and adds the four new bits, weighted by alpha^(3j), alpha^(2j), alpha^j and 1. The even syndromes are not accumulated. Each one is taken from an odd syndrome by repeated squaring, because S_2i = (S_i)^2 for a binary code.

A code length that is not a multiple of four is handled by zero-filling the high end of the first beat. A codeword of n bits therefore takes ceil(n/4) beat cycles. In the cycle after the last beat, a one-cycle done pulse marks the syndrome vector as valid. At the same time a flag reports whether every syndrome is zero, so that the error-locator stage can be skipped.

Top module: `bch_syndrome4`

## Requirements
- R1: While reset is held and in the cycle after it is released, syn_done is 0, syn_zero is 0 and every syndrome field of syn_out is zero.
- R2: The received word is r(x) = sum of r_i x^i. Its first transmitted bit is the coefficient of x^(n-1). In each beat, in_bits[3] is the highest-order bit and in_bits[0] the lowest. For odd j, field j of syn_out is r(alpha^j). Field j occupies syn_out[(j-1)*M +: M], in polynomial basis, with alpha = x and reduction by the POLY polynomial.
- R3: syn_done is 1 for exactly one cycle: the cycle after the clock edge that accepts a beat with in_last high. It is 0 in the cycle after an accepted beat that is not last. With back-to-back beats, an n-bit codeword needs ceil(n/4) beat cycles before done.
- R4: The first valid beat after reset, or after an accepted last beat, starts a new codeword. The values left over from the previous codeword have no effect on the new result, including when that beat arrives in the same cycle as syn_done.
- R5: A cycle with in_valid low has no effect, whatever in_bits and in_last hold. Stall cycles inside a codeword leave its result unchanged, and syn_out, syn_zero and syn_done keep their values during idle cycles after a result.
- R6: When n is not a multiple of four, the unused high-order bits of the first beat are zero. Whole leading beats of zeros likewise leave every syndrome unchanged.
- R7: syn_zero is updated on the edge that accepts a last beat. It is 1 exactly when all 2T syndromes of that codeword are zero, and it holds that value until the next last beat is accepted.
- R8: For even j, field j of syn_out equals r(alpha^j). The unit obtains it as the square of field j/2.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock, rising edge active |
| rst | input | 1 | Synchronous reset, active high |
| in_valid | input | 1 | The beat on in_bits is accepted in this cycle |
| in_last | input | 1 | This accepted beat ends the codeword |
| in_bits | input | 4 | Four received bits, bit 3 highest order |
| syn_out | output | 2*T*M | Syndromes S1..S2T, field j at bits (j-1)*M upward |
| syn_done | output | 1 | One-cycle pulse: syn_out holds a finished codeword |
| syn_zero | output | 1 | All syndromes of the last finished codeword are zero |

## Verification
The hardest case to reach from the ports is a new first beat arriving in the very cycle that done is high. In that cycle the accumulators must drop the finished result and still present it on the outputs. The bench reaches this case by streaming codewords back to back. It samples each result just before the next word's first beat takes effect. It also inserts stall cycles carrying junk bits and junk last flags inside words. Every length from 1 to 4 bits and all 2048 words of length 11 are swept. The length-11 sweep necessarily includes the nonzero codeword whose syndromes all vanish, which drives the all-zero flag high from a nonzero input.

// File: rtl/bch_syn_pkg.sv
package bch_syn_pkg;

    localparam int BEAT_BITS = 4;

    typedef struct packed {
        logic                 valid;
        logic                 last;
        logic [BEAT_BITS-1:0] bits;
    } beat_t;

    // Mask of the low m bits.
    function automatic logic [31:0] field_mask(input int m);
        return 32'((64'd1 << m) - 64'd1);
    endfunction

    // Elaboration-time field product for constant derivation.
    function automatic logic [31:0] const_mul(input logic [31:0] a,
                                              input logic [31:0] b,
                                              input int          m,
                                              input logic [31:0] poly);
        logic [31:0] p;
        logic [31:0] mask;
        logic        msb;
        mask = field_mask(m);
        p    = '0;
        for (int i = 31; i >= 0; i--) begin
            if (i < m) begin
                msb = p[m-1];
                p   = (p << 1) & mask;
                if (msb) p = p ^ (poly & mask);
                if (b[i]) p = p ^ (a & mask);
            end
        end
        return p;
    endfunction

    // alpha^e in polynomial basis, alpha = x.
    function automatic logic [31:0] alpha_pow(input logic [31:0] e,
                                              input int          m,
                                              input logic [31:0] poly);
        logic [31:0] ord;
        logic [31:0] ee;
        logic [31:0] r;
        logic [31:0] b;
        ord = field_mask(m);
        ee  = e % ord;
        r   = 32'd1;
        b   = 32'd2;
        for (int i = 0; i < 32; i++) begin
            if (ee[i]) r = const_mul(r, b, m, poly);
            b = const_mul(b, b, m, poly);
        end
        return r;
    endfunction

    // Odd factor of a positive index.
    function automatic int odd_part(input int j);
        int v;
        v = j;
        for (int i = 0; i < 32; i++) begin
            if ((v % 2) == 0 && v != 0) v = v / 2;
        end
        return v;
    endfunction

    // Number of factors of two in a positive index.
    function automatic int two_exp(input int j);
        int v;
        int k;
        v = j;
        k = 0;
        for (int i = 0; i < 32; i++) begin
            if ((v % 2) == 0 && v != 0) begin
                v = v / 2;
                k = k + 1;
            end
        end
        return k;
    endfunction

endpackage

// File: rtl/bch_gf_mult.sv
module bch_gf_mult #(
    parameter int          M    = 16,
    parameter int unsigned POLY = 32'h1100B
) (
    input  logic [M-1:0] a,
    input  logic [M-1:0] b,
    output logic [M-1:0] y
);

    localparam logic [M-1:0] RED = M'(POLY);

    // Shift-and-add product, reduced one step per bit of b.
    always_comb begin
        logic [M-1:0] p;
        p = '0;
        for (int i = M - 1; i >= 0; i--) begin
            p = {p[M-2:0], 1'b0} ^ (p[M-1] ? RED : '0);
            if (b[i]) p = p ^ a;
        end
        y = p;
    end

endmodule

// File: rtl/bch_gf_sqr_chain.sv
module bch_gf_sqr_chain #(
    parameter int          M    = 16,
    parameter int unsigned POLY = 32'h1100B,
    parameter int          K    = 1
) (
    input  logic [M-1:0] a,
    output logic [M-1:0] y
);

    localparam logic [M-1:0] RED = M'(POLY);

    // K successive squarings: y = a^(2^K).
    always_comb begin
        logic [M-1:0] v;
        logic [M-1:0] p;
        v = a;
        for (int s = 0; s < K; s++) begin
            p = '0;
            for (int i = M - 1; i >= 0; i--) begin
                p = {p[M-2:0], 1'b0} ^ (p[M-1] ? RED : '0);
                if (v[i]) p = p ^ v;
            end
            v = p;
        end
        y = v;
    end

endmodule

// File: rtl/bch_syn_odd_acc.sv
module bch_syn_odd_acc #(
    parameter int          M    = 16,
    parameter int unsigned POLY = 32'h1100B,
    parameter int          J    = 1
) (
    input  logic                             clk,
    input  logic                             rst,
    input  logic                             beat_valid,
    input  logic                             beat_first,
    input  logic [bch_syn_pkg::BEAT_BITS-1:0] beat_bits,
    output logic [M-1:0]                     acc,
    output logic [M-1:0]                     acc_nxt
);

    localparam logic [M-1:0] W1 = M'(bch_syn_pkg::alpha_pow(32'(J), M, POLY));
    localparam logic [M-1:0] W2 = M'(bch_syn_pkg::alpha_pow(32'(2 * J), M, POLY));
    localparam logic [M-1:0] W3 = M'(bch_syn_pkg::alpha_pow(32'(3 * J), M, POLY));
    localparam logic [M-1:0] W4 = M'(bch_syn_pkg::alpha_pow(32'(4 * J), M, POLY));

    logic [M-1:0] base;
    logic [M-1:0] shifted;

    // A first beat starts from zero instead of the previous word's value.
    assign base = beat_first ? '0 : acc;

    bch_gf_mult #(.M(M), .POLY(POLY)) u_step (
        .a (base),
        .b (W4),
        .y (shifted)
    );

    always_comb begin
        acc_nxt = shifted
                ^ (beat_bits[3] ? W3 : '0)
                ^ (beat_bits[2] ? W2 : '0)
                ^ (beat_bits[1] ? W1 : '0)
                ^ {{(M-1){1'b0}}, beat_bits[0]};
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            acc <= '0;
        end else if (beat_valid) begin
            acc <= acc_nxt;
        end
    end

    assert_hold_R5: assert property (@(posedge clk) disable iff (rst)
        !beat_valid |=> $stable(acc));

    assert_first_clear_R4: assert property (@(posedge clk) disable iff (rst)
        (beat_valid && beat_first && beat_bits == '0) |=> (acc == '0));

endmodule

// File: rtl/bch_syn_ctrl.sv
module bch_syn_ctrl (
    input  logic clk,
    input  logic rst,
    input  logic beat_valid,
    input  logic beat_last,
    output logic beat_first,
    output logic done
);

    logic await_first;

    always_ff @(posedge clk) begin
        if (rst) begin
            await_first <= 1'b1;
            done        <= 1'b0;
        end else begin
            done <= beat_valid && beat_last;
            if (beat_valid) await_first <= beat_last;
        end
    end

    assign beat_first = beat_valid && await_first;

    assert_done_single_R3: assert property (@(posedge clk) disable iff (rst)
        (done && !(beat_valid && beat_last)) |=> !done);

    assert_first_after_done_R4: assert property (@(posedge clk) disable iff (rst)
        (done && beat_valid) |-> beat_first);

endmodule

// File: rtl/bch_syndrome4.sv
module bch_syndrome4 #(
    parameter int          M    = 16,
    parameter int unsigned POLY = 32'h1100B,
    parameter int          T    = 4
) (
    input  logic               clk,
    input  logic               rst,
    input  logic               in_valid,
    input  logic               in_last,
    input  logic [3:0]         in_bits,
    output logic [2*T*M-1:0]   syn_out,
    output logic               syn_done,
    output logic               syn_zero
);

    import bch_syn_pkg::*;

    localparam int NSYN  = 2 * T;
    localparam int SYN_W = NSYN * M;

    beat_t        beat;
    logic         first;
    logic [M-1:0] odd_acc [T];
    logic [M-1:0] odd_nxt [T];
    logic         nxt_nonzero;

    assign beat = {in_valid, in_last, in_bits};

    bch_syn_ctrl u_ctrl (
        .clk        (clk),
        .rst        (rst),
        .beat_valid (beat.valid),
        .beat_last  (beat.last),
        .beat_first (first),
        .done       (syn_done)
    );

    for (genvar i = 0; i < T; i++) begin : g_acc
        bch_syn_odd_acc #(.M(M), .POLY(POLY), .J(2 * i + 1)) u_acc (
            .clk        (clk),
            .rst        (rst),
            .beat_valid (beat.valid),
            .beat_first (first),
            .beat_bits  (beat.bits),
            .acc        (odd_acc[i]),
            .acc_nxt    (odd_nxt[i])
        );
    end

    for (genvar j = 1; j <= NSYN; j++) begin : g_syn
        if ((j % 2) == 1) begin : g_odd
            assign syn_out[(j-1)*M +: M] = odd_acc[(j-1)/2];
        end else begin : g_even
            localparam int SRC = (odd_part(j) - 1) / 2;
            localparam int NSQ = two_exp(j);
            bch_gf_sqr_chain #(.M(M), .POLY(POLY), .K(NSQ)) u_sq (
                .a (odd_acc[SRC]),
                .y (syn_out[(j-1)*M +: M])
            );
        end
    end

    // Even syndromes are squares of odd ones, so the odd set decides the flag.
    always_comb begin
        nxt_nonzero = 1'b0;
        for (int i = 0; i < T; i++) begin
            nxt_nonzero = nxt_nonzero | (odd_nxt[i] != '0);
        end
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            syn_zero <= 1'b0;
        end else if (beat.valid && beat.last) begin
            syn_zero <= !nxt_nonzero;
        end
    end

    assert_zero_flag_R7: assert property (@(posedge clk) disable iff (rst)
        syn_done |-> (syn_zero == (syn_out == SYN_W'(0))));

    assert_flag_hold_R7: assert property (@(posedge clk) disable iff (rst)
        !(in_valid && in_last) |=> $stable(syn_zero));

endmodule

// File: tb/bch_syndrome4_tb.sv
module bch_syndrome4_tb;

    localparam int CLK_PERIOD = 10;
    localparam int TM = 4;
    localparam int TT = 3;
    localparam int SW = 2 * TT * TM;

    logic          clk = 1'b0;
    logic          rst = 1'b1;
    logic          in_valid = 1'b0;
    logic          in_last = 1'b0;
    logic [3:0]    in_bits = 4'd0;
    logic [SW-1:0] syn_out;
    logic          syn_done;
    logic          syn_zero;

    int checks = 0;
    int errors = 0;
    bit finished = 1'b0;

    always #(CLK_PERIOD / 2) clk = ~clk;

    bch_syndrome4 #(.M(TM), .POLY(32'h13), .T(TT)) u_dut (
        .clk      (clk),
        .rst      (rst),
        .in_valid (in_valid),
        .in_last  (in_last),
        .in_bits  (in_bits),
        .syn_out  (syn_out),
        .syn_done (syn_done),
        .syn_zero (syn_zero)
    );

    // alpha^e in GF(16) with x^4+x+1, by repeated multiplication by x.
    function automatic logic [3:0] apow(input int e);
        logic [4:0] v;
        v = 5'd1;
        for (int i = 0; i < e; i++) begin
            v = v << 1;
            if (v[4]) v = v ^ 5'h13;
        end
        return v[3:0];
    endfunction

    function automatic logic [SW-1:0] ref_syn(input logic [15:0] r, input int n);
        logic [SW-1:0] s;
        logic [3:0]    a;
        s = '0;
        for (int j = 1; j <= 2 * TT; j++) begin
            a = 4'd0;
            for (int i = 0; i < n; i++) begin
                if (r[i]) a = a ^ apow(i * j);
            end
            s[(j-1)*TM +: TM] = a;
        end
        return s;
    endfunction

    function automatic logic [SW-1:0] even_mask();
        logic [SW-1:0] m;
        m = '0;
        for (int j = 2; j <= 2 * TT; j += 2) m[(j-1)*TM +: TM] = 4'hF;
        return m;
    endfunction

    task automatic chk(input bit ok, input string what, input logic [63:0] act, input logic [63:0] exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s actual=%0h expected=%0h", what, act, exp);
        end
    endtask

    // Called and returning on a falling edge.
    task automatic send_word(input logic [15:0] rin, input int n, input int gap, input string tag);
        logic [15:0]   r;
        logic [SW-1:0] e;
        logic [SW-1:0] em;
        int            nb;
        r  = rin & 16'((32'd1 << n) - 1);
        e  = ref_syn(r, n);
        em = even_mask();
        nb = (n + 3) / 4;
        for (int k = 0; k < nb; k++) begin
            in_valid = 1'b1;
            in_last  = (k == nb - 1);
            in_bits  = r[4*(nb-1-k) +: 4];
            @(negedge clk);
            if (k == 0 && nb > 1)
                chk(syn_done == 1'b0, "R3 done low after non-last beat", 64'(syn_done), 64'd0);
            if (k < nb - 1 && gap > 0) begin
                in_valid = 1'b0;
                in_last  = 1'($urandom);
                in_bits  = 4'($urandom);
                repeat (gap) @(negedge clk);
            end
        end
        in_valid = 1'b0;
        in_last  = 1'b0;
        chk(syn_done == 1'b1, {"R3 done after last ", tag}, 64'(syn_done), 64'd1);
        chk((syn_out & ~em) == (e & ~em), {"R2 odd syndromes ", tag}, 64'(syn_out), 64'(e));
        chk((syn_out & em) == (e & em), {"R8 even syndromes ", tag}, 64'(syn_out), 64'(e));
        chk(syn_zero == (e == '0), {"R7 zero flag ", tag}, 64'(syn_zero), 64'(e == '0));
    endtask

    initial begin
        logic [SW-1:0] held;
        logic          zheld;
        rst = 1'b1;
        repeat (3) @(negedge clk);
        chk(syn_done == 1'b0 && syn_zero == 1'b0 && syn_out == '0, "R1 reset outputs",
            64'(syn_out), 64'd0);
        rst = 1'b0;
        @(negedge clk);
        chk(syn_done == 1'b0 && syn_zero == 1'b0 && syn_out == '0, "R1 after reset",
            64'(syn_out), 64'd0);

        // R6: short lengths, high end of the single beat zero-filled.
        for (int n = 1; n <= 4; n++)
            for (int v = 0; v < (1 << n); v++)
                send_word(16'(v), n, 0, "R6 short length");

        // R2 / R4: exhaustive length 11, back to back.
        for (int v = 0; v < 2048; v++)
            send_word(16'(v), 11, 0, "R4 back-to-back n=11");

        // R5: random words with stalls carrying junk.
        for (int n = 5; n <= 15; n++)
            for (int c = 0; c < 40; c++)
                send_word(16'($urandom), n, int'($urandom % 3), "R5 stalls");

        // R6: extra whole leading zero beats keep the result.
        send_word(16'h0016, 5, 0, "R6 n=5");
        send_word(16'h0016, 9, 0, "R6 one zero beat");
        send_word(16'h0016, 13, 1, "R6 two zero beats");

        // R4: a zero word straight after a nonzero one.
        send_word(16'h05A3, 11, 0, "R4 nonzero word");
        send_word(16'h0000, 11, 0, "R4 zero word after nonzero");
        send_word(16'h7FFF, 15, 0, "R4 full word");

        // R5 / R7: idle cycles with junk hold the result.
        held  = syn_out;
        zheld = syn_zero;
        for (int c = 0; c < 4; c++) begin
            in_valid = 1'b0;
            in_last  = 1'b1;
            in_bits  = 4'($urandom);
            @(negedge clk);
            chk(syn_done == 1'b0, "R3 no done while idle", 64'(syn_done), 64'd0);
            chk(syn_out == held, "R5 syndromes held while idle", 64'(syn_out), 64'(held));
            chk(syn_zero == zheld, "R7 flag held while idle", 64'(syn_zero), 64'(zheld));
        end
        in_last = 1'b0;

        finished = 1'b1;
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

    initial begin
        repeat (200000) @(posedge clk);
        if (!finished) begin
            errors++;
            $display("FAIL watchdog expired actual=hung expected=done");
            $display("Simulation finished: %0d checks, %0d errors", checks, errors);
            $finish;
        end
    end

endmodule